// File: doc/BRIEF.md
# Interrupt Flag Register with Live Condition Bits

This block holds the 32 interrupt request flags of one processor. Most flags are latched: a one-cycle event pulse sets them and software acknowledges them by writing ones. A few positions are never stored. They are derived every cycle from live hardware levels, namely the inter-processor queue send side being empty, the inter-processor queue receive side holding data, and (on the main processor only) the fill level of a command queue. Such a bit stays asserted for as long as its condition holds, and no acknowledge can remove it.

The read value is the latched flags ORed with the derived flags. An enable mask and a master enable, both held inside the block, gate that value onto a single interrupt line to the processor. One parameter selects the main or the secondary processor variant. In the secondary variant, bit 21 is an ordinary latched flag.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, no latched flag is set, the enable mask is 0 and the master enable is 0.
- R2: A 1 on `evt_i[n]` sets latched flag n on the next clock edge. The flag then stays set until it is acknowledged.
- R3: A write with `wr_sel_i` = 0 clears each latched flag whose data bit is 1 and whose byte lane is enabled in `wr_be_i`. Bit 0 of `wr_be_i` covers bits 7:0 and bit 3 covers bits 31:24. A write with `wr_sel_i` = 3 changes nothing.
- R4: When an event pulse and an acknowledge hit the same flag in the same cycle, the flag is set.
- R5: Bit 17 follows `ipc_send_empty_i` and bit 18 follows `ipc_recv_nonempty_i`. Acknowledges and event pulses at these positions have no effect.
- R6: In the main variant, bit 21 follows the command queue condition. In mode 0 it is never set. In mode 1 it is set while the count is 127 or less. In mode 2 it is set while the count is 0. In mode 3 it is never set. Acknowledges and pulses at bit 21 have no effect.
- R7: In the secondary variant (`MAIN_CPU` = 0), bit 21 is an ordinary latched flag that is set by `evt_i[21]` and cleared by an acknowledge.
- R8: `flags_o` is the latched flags ORed with the derived flags.
- R9: A write with `wr_sel_i` = 1 replaces the enabled byte lanes of the enable mask. A write with `wr_sel_i` = 2 and `wr_be_i[0]` = 1 loads `wr_data_i[0]` into the master enable.
- R10: `irq_o` is 1 exactly when the master enable is 1 and `flags_o` ANDed with the mask is nonzero, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | One-cycle set pulses for the latched flags |
| ipc_send_empty_i | input | 1 | Level: the send queue is empty |
| ipc_recv_nonempty_i | input | 1 | Level: the receive queue holds data |
| cmd_count_i | input | CNT_W | Entries in the command queue |
| cmd_mode_i | input | 2 | Condition mode for bit 21 |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 flags (acknowledge), 1 mask, 2 master, 3 none |
| wr_be_i | input | 4 | Byte lane enables |
| wr_data_i | input | 32 | Write data |
| flags_o | output | 32 | Effective flags (read value) |
| mask_o | output | 32 | Enable mask |
| master_o | output | 1 | Master enable |
| irq_o | output | 1 | Interrupt request line |

## Verification
The assertions assume that `cmd_mode_i` and `cmd_count_i` are stable for whole cycles and that the count never exceeds the queue depth. The stimulus keeps the count within 0 to 256. The clear and hold properties also assume that event pulses last exactly one cycle. The bench changes every input only on the falling edge, drives each pulse for one step, and sets the next step's pulses afresh. Both variants share the same stimulus, so each pulse and acknowledge is applied to the main and the secondary variant at the same time.

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter bit MAIN_CPU   = 1'b1,
  parameter int CNT_W      = 9,
  parameter int HALF_LIMIT = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      evt_i,
  input  logic             ipc_send_empty_i,
  input  logic             ipc_recv_nonempty_i,
  input  logic [CNT_W-1:0] cmd_count_i,
  input  logic [1:0]       cmd_mode_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [3:0]       wr_be_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      flags_o,
  output logic [31:0]      mask_o,
  output logic             master_o,
  output logic             irq_o
);

  localparam logic [1:0] SEL_FLAGS  = 2'd0;
  localparam logic [1:0] SEL_MASK   = 2'd1;
  localparam logic [1:0] SEL_MASTER = 2'd2;
  localparam logic [31:0] LIVE_MASK = MAIN_CPU ? 32'h0026_0000 : 32'h0006_0000;
  localparam logic [CNT_W-1:0] HALF = CNT_W'(HALF_LIMIT);

  logic [31:0] stored_q, mask_q, lanes, ack, live;
  logic        master_q, cmd_hit;

  assign lanes = {{8{wr_be_i[3]}}, {8{wr_be_i[2]}}, {8{wr_be_i[1]}}, {8{wr_be_i[0]}}};
  assign ack   = (wr_en_i && wr_sel_i == SEL_FLAGS) ? (wr_data_i & lanes & ~LIVE_MASK) : 32'd0;

  always_comb begin
    case (cmd_mode_i)
      2'd1:    cmd_hit = (cmd_count_i <= HALF);
      2'd2:    cmd_hit = (cmd_count_i == '0);
      default: cmd_hit = 1'b0;
    endcase
  end

  assign live = {10'd0, MAIN_CPU ? cmd_hit : 1'b0, 2'd0,
                 ipc_recv_nonempty_i, ipc_send_empty_i, 17'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored_q <= '0;
      mask_q   <= '0;
      master_q <= 1'b0;
    end else begin
      stored_q <= (stored_q & ~ack) | (evt_i & ~LIVE_MASK);
      if (wr_en_i && wr_sel_i == SEL_MASK)
        mask_q <= (mask_q & ~lanes) | (wr_data_i & lanes);
      if (wr_en_i && wr_sel_i == SEL_MASTER && wr_be_i[0])
        master_q <= wr_data_i[0];
    end
  end

  assign flags_o  = stored_q | live;
  assign mask_o   = mask_q;
  assign master_o = master_q;
  assign irq_o    = master_q && |(flags_o & mask_q);

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[0] |=> flags_o[0]);

  a_r4_set_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[3] && wr_en_i && wr_sel_i == SEL_FLAGS && wr_be_i[0] && wr_data_i[3]) |=> flags_o[3]);

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i[8] && wr_en_i && wr_sel_i == SEL_FLAGS && wr_be_i[1] && wr_data_i[8]) |=> !flags_o[8]);

  a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i[0] && !(wr_en_i && wr_sel_i == SEL_FLAGS && wr_be_i[0] && wr_data_i[0])) |=> $stable(flags_o[0]));

  a_r5_send_level_seen: assert property (@(posedge clk) disable iff (!rst_n)
    ipc_send_empty_i |-> flags_o[17]);

  a_r9_master_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_MASTER && wr_be_i[0]) |=> master_o == $past(wr_data_i[0]));

  a_r10_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> master_o);

  if (MAIN_CPU) begin : g_main_chk
    a_r6_empty_mode_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_mode_i == 2'd2 && cmd_count_i != '0) |-> !flags_o[21]);
    a_r6_off_modes: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_mode_i == 2'd0 || cmd_mode_i == 2'd3) |-> !flags_o[21]);
  end

endmodule

// File: tb/test_irq_flag_reg.sv
`timescale 1ns/1ps
module test_irq_flag_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic        snd = 1'b0, rcv = 1'b0;
  logic [8:0]  cnt = '0;
  logic [1:0]  mode = '0;
  logic        wen = 1'b0;
  logic [1:0]  sel = '0;
  logic [3:0]  be = '0;
  logic [31:0] data = '0;

  logic [31:0] fm, fs, mkm, mks;
  logic        msm, mss, im, is;

  always #10 clk = ~clk;

  irq_flag_reg #(.MAIN_CPU(1'b1)) i_irq_flag_reg (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ipc_send_empty_i(snd),
    .ipc_recv_nonempty_i(rcv), .cmd_count_i(cnt), .cmd_mode_i(mode),
    .wr_en_i(wen), .wr_sel_i(sel), .wr_be_i(be), .wr_data_i(data),
    .flags_o(fm), .mask_o(mkm), .master_o(msm), .irq_o(im));

  irq_flag_reg #(.MAIN_CPU(1'b0)) i_irq_flag_reg_sec (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ipc_send_empty_i(snd),
    .ipc_recv_nonempty_i(rcv), .cmd_count_i(cnt), .cmd_mode_i(mode),
    .wr_en_i(wen), .wr_sel_i(sel), .wr_be_i(be), .wr_data_i(data),
    .flags_o(fs), .mask_o(mks), .master_o(mss), .irq_o(is));

  typedef struct {
    logic [31:0] f_m, f_s, mask;
    logic        i_m, i_s, master;
    string       req;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [31:0] m_st = '0, s_st = '0, r_mask = '0;
  logic        r_master = 1'b0;

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.req, "main flags", fm, it.f_m);
      cmp(it.req, "sec flags", fs, it.f_s);
      cmp(it.req, "main irq", {31'd0, im}, {31'd0, it.i_m});
      cmp(it.req, "sec irq", {31'd0, is}, {31'd0, it.i_s});
      cmp(it.req, "mask", mkm, it.mask);
      cmp(it.req, "master", {31'd0, msm}, {31'd0, it.master});
    end
  end

  task automatic step(input logic [31:0] e, input logic s, input logic r,
                      input logic [8:0] c, input logic [1:0] md,
                      input logic we, input logic [1:0] sl, input logic [3:0] b,
                      input logic [31:0] d, input string req);
    logic [31:0] lanes, ack, gm, gs;
    logic        g21;
    item_t it;
    @(negedge clk);
    evt = e; snd = s; rcv = r; cnt = c; mode = md;
    wen = we; sel = sl; be = b; data = d;
    lanes = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    ack = (we && sl == 2'd0) ? (d & lanes) : 32'd0;
    m_st = (m_st & ~(ack & ~32'h0026_0000)) | (e & ~32'h0026_0000);
    s_st = (s_st & ~(ack & ~32'h0006_0000)) | (e & ~32'h0006_0000);
    if (we && sl == 2'd1) r_mask = (r_mask & ~lanes) | (d & lanes);
    if (we && sl == 2'd2 && b[0]) r_master = d[0];
    g21 = (md == 2'd1) ? (c <= 9'd127) : (md == 2'd2) ? (c == 9'd0) : 1'b0;
    gs = (32'(r) << 18) | (32'(s) << 17);
    gm = gs | (32'(g21) << 21);
    it.f_m = m_st | gm;
    it.f_s = s_st | gs;
    it.mask = r_mask;
    it.master = r_master;
    it.i_m = r_master && |(it.f_m & r_mask);
    it.i_s = r_master && |(it.f_s & r_mask);
    it.req = req;
    q.push_back(it);
  endtask

  task automatic ev(input logic [31:0] e, input string req);
    step(e, 1'b0, 1'b0, 9'd0, 2'd0, 1'b0, 2'd0, 4'd0, 32'd0, req);
  endtask

  task automatic wr(input logic [31:0] e, input logic [1:0] sl, input logic [3:0] b,
                    input logic [31:0] d, input string req);
    step(e, 1'b0, 1'b0, 9'd0, 2'd0, 1'b1, sl, b, d, req);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    cmp("R1", "flags after reset", fm, 32'd0);
    cmp("R1", "mask after reset", mkm, 32'd0);
    cmp("R1", "master after reset", {31'd0, msm}, 32'd0);
    cmp("R1", "irq after reset", {31'd0, im}, 32'd0);

    ev(32'h8000_0101, "R2");
    ev(32'd0, "R2");
    wr(32'd0, 2'd0, 4'b0010, 32'hFFFF_FFFF, "R3");
    wr(32'd0, 2'd3, 4'b1111, 32'hFFFF_FFFF, "R3");
    wr(32'h0000_0009, 2'd0, 4'b0001, 32'h0000_0009, "R4");
    wr(32'd0, 2'd0, 4'b1110, 32'h0000_0009, "R3");
    wr(32'd0, 2'd0, 4'b1111, 32'h8000_0009, "R3");
    step(32'd0, 1'b1, 1'b1, 9'd0, 2'd0, 1'b1, 2'd0, 4'b0100, 32'h0006_0000, "R5");
    step(32'h0006_0000, 1'b0, 1'b1, 9'd0, 2'd0, 1'b0, 2'd0, 4'd0, 32'd0, "R5");
    ev(32'd0, "R5");
    step(32'd0, 1'b0, 1'b0, 9'd127, 2'd1, 1'b0, 2'd0, 4'd0, 32'd0, "R6");
    step(32'd0, 1'b0, 1'b0, 9'd128, 2'd1, 1'b0, 2'd0, 4'd0, 32'd0, "R6");
    step(32'd0, 1'b0, 1'b0, 9'd0, 2'd2, 1'b1, 2'd0, 4'b0100, 32'h0020_0000, "R6");
    step(32'd0, 1'b0, 1'b0, 9'd1, 2'd2, 1'b0, 2'd0, 4'd0, 32'd0, "R6");
    step(32'd0, 1'b0, 1'b0, 9'd0, 2'd3, 1'b0, 2'd0, 4'd0, 32'd0, "R6");
    step(32'd0, 1'b0, 1'b0, 9'd256, 2'd1, 1'b0, 2'd0, 4'd0, 32'd0, "R6");
    ev(32'h0020_0000, "R7");
    ev(32'd0, "R7");
    wr(32'd0, 2'd0, 4'b0100, 32'h0020_0000, "R7");
    step(32'd0, 1'b0, 1'b1, 9'd0, 2'd1, 1'b0, 2'd0, 4'd0, 32'd0, "R8");
    wr(32'h0000_0001, 2'd1, 4'b0001, 32'h0000_0001, "R9");
    wr(32'd0, 2'd2, 4'b0001, 32'h0000_0001, "R10");
    wr(32'd0, 2'd0, 4'b0001, 32'h0000_0001, "R10");
    wr(32'd0, 2'd1, 4'b1000, 32'hFFFF_FFFF, "R9");
    ev(32'h0400_0000, "R10");
    wr(32'd0, 2'd2, 4'b0010, 32'h0000_0000, "R9");
    wr(32'd0, 2'd2, 4'b0001, 32'h0000_0000, "R10");
    step(32'd0, 1'b1, 1'b0, 9'd0, 2'd2, 1'b1, 2'd1, 4'b0100, 32'h0026_0000, "R10");
    wr(32'd0, 2'd2, 4'b0001, 32'h0000_0001, "R10");
    step(32'd0, 1'b1, 1'b0, 9'd0, 2'd2, 1'b1, 2'd0, 4'b1111, 32'hFFFF_FFFF, "R5");

    while (q.size() > 0) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule